// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls one bank of up to 32 I/O pads. Each pad is owned either by the general-purpose I/O logic or by one of two on-chip peripheral functions, called route A and route B here. Every per-pin setting is held in a register that software never rewrites whole. Each setting has a write-1-to-set address, a write-1-to-clear address and a read-only status address. Each bit written as 1 changes only its own pin, so two drivers that own different pins can never undo each other's changes.

On the pad side the block produces an output enable, an output value and a pull-up enable for each pin. Pad inputs pass through a synchronizer. An optional per-pin two-sample glitch filter follows, and the result reaches a readable pin-level register. Open-drain operation (multi-drive) makes a pin drive low only. The pin releases the pad whenever its selected output value is 1. A global pin number maps to a bank through its upper bits and to a pin inside the bank through its low five bits. The bank decode is left to the bus fabric.

Top module: `gpmx_bank`

## Requirements
- R1: After reset every pin has these settings: owned by GPIO, output disabled, output data 0, multi-drive off, filter off, pull-up on (pull-up status reads 0) and route A selected. pad_oe is all 0 and pad_pu is all 1.
- R2: Control k has its set address at 4k, its clear address at 4k+1 and its status address at 4k+2. The controls are: 0 ownership (1 = GPIO), 1 output enable, 2 filter, 3 output data, 5 multi-drive, 6 pull-up, 7 route. A write to a set address sets exactly the bits written as 1. A write to a clear address clears exactly those bits. All other bits keep their value.
- R3: A set on the ownership control (address 0) hands pins to GPIO, and a clear (address 1) hands them to a peripheral. The ownership status (address 2) reads 1 for each GPIO-owned pin.
- R4: Address 28 selects route A and address 29 selects route B. The route status (address 30) reads 1 for pins on route B. A pin not owned by GPIO takes its output enable and output value from the selected route's inputs.
- R5: On a GPIO-owned pin, pad_out equals the output-data bit and pad_oe equals the output-enable bit, provided multi-drive is off.
- R6: With multi-drive on, pad_oe is 0 whenever the pin's selected output value is 1. When the value is 0, the pin follows the selected output enable. This holds for GPIO and peripheral pins alike.
- R7: Address 24 enables a pin's pull-up and address 25 disables it. The status at address 26 reads 1 for each pin whose pull-up is disabled. pad_pu is 1 where the pull-up is enabled.
- R8: The pin-level register (address 18) shows an unfiltered pad level change after two rising clock edges, and not after one.
- R9: On a pin with the filter on, a new level appears at address 18 only after two consecutive equal synchronized samples. This takes four rising edges from the pad change. A one-cycle pad pulse never appears.
- R10: Writes to status addresses and to unused addresses change nothing. Reads from set, clear and unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address of the register port |
| bus_wdata | input | N_PINS | Write data, one bit per pin |
| bus_rdata | output | N_PINS | Combinational read data for bus_addr |
| pad_in | input | N_PINS | Asynchronous pad input levels |
| pad_oe | output | N_PINS | Pad output enable |
| pad_out | output | N_PINS | Pad output value |
| pad_pu | output | N_PINS | Pad pull-up enable |
| pa_oe | input | N_PINS | Route A output enable |
| pa_out | input | N_PINS | Route A output value |
| pb_oe | input | N_PINS | Route B output enable |
| pb_out | input | N_PINS | Route B output value |

## Verification
Several corner cases get targeted stimulus:
- Set and clear writes that overlap earlier bits. A design that wrote the word instead of merging it would wipe neighbouring pins.
- Multi-drive on a pin whose value is 1, on both GPIO and peripheral pins. A design that masked only the GPIO path would drive a peripheral's high level onto the open-drain pin.
- Route switches of part of a byte while the pins are not GPIO-owned. They catch a swapped or ignored route bit.
- Level changes sampled one edge early and exactly on time, plus a single-cycle pulse on a filtered pin. A missing synchronizer stage or a one-sample filter shows the value too soon or lets the pulse through.

// File: rtl/gpmx_pkg.sv
`timescale 1ns/1ps
package gpmx_pkg;
   // Control slots; slot k owns word addresses 4k (set), 4k+1 (clear), 4k+2 (status).
   localparam int CTL_N    = 8;
   localparam int C_OWN    = 0;   // 1 = GPIO owns the pin
   localparam int C_OE     = 1;
   localparam int C_FLT    = 2;
   localparam int C_DOUT   = 3;
   localparam int C_PIN    = 4;   // read-only pin level, no storage
   localparam int C_MD     = 5;
   localparam int C_PUON   = 6;   // stored as "pull-up on", viewed inverted
   localparam int C_SELA   = 7;   // stored as "route A", viewed inverted

   localparam int OFS_SET  = 0;
   localparam int OFS_CLR  = 1;
   localparam int OFS_STAT = 2;

   function automatic logic ctl_rst(input int k);
      return (k == C_OWN) || (k == C_PUON) || (k == C_SELA);
   endfunction

   function automatic logic ctl_inv(input int k);
      return (k == C_PUON) || (k == C_SELA);
   endfunction
endpackage

// File: rtl/gpmx_setclr.sv
`timescale 1ns/1ps
module gpmx_setclr #(
   parameter int   W       = 32,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("gpmx_setclr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= {W{RST_VAL}};
      else if (set_we) q <= q | wdata;
      else if (clr_we) q <= q & ~wdata;
   end
endmodule

// File: rtl/gpmx_sync.sv
`timescale 1ns/1ps
module gpmx_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpmx_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpmx_filter.sv
`timescale 1ns/1ps
module gpmx_filter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic [W-1:0] prev_q;

   // A bit moves only when the current and the previous sample agree.
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[b] <= 1'b0;
            q[b]      <= 1'b0;
         end else begin
            prev_q[b] <= din[b];
            if (din[b] == prev_q[b]) q[b] <= din[b];
         end
      end
   end
endmodule

// File: rtl/gpmx_bank.sv
`timescale 1ns/1ps
module gpmx_bank
   import gpmx_pkg::*;
#(
   parameter int N_PINS      = 32,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_PINS-1:0] bus_wdata,
   output logic [N_PINS-1:0] bus_rdata,
   input  logic [N_PINS-1:0] pad_in,
   output logic [N_PINS-1:0] pad_oe,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] pad_pu,
   input  logic [N_PINS-1:0] pa_oe,
   input  logic [N_PINS-1:0] pa_out,
   input  logic [N_PINS-1:0] pb_oe,
   input  logic [N_PINS-1:0] pb_out
);
   localparam int IDX_W = $clog2(CTL_N);

   if (N_PINS < 1 || N_PINS > 32) begin : g_bad_pins
      $error("gpmx_bank: N_PINS must be 1..32");
   end
   if (ADDR_W < IDX_W + 3) begin : g_bad_addr
      $error("gpmx_bank: ADDR_W too small for the control map");
   end

   logic [N_PINS-1:0] ctl_q    [CTL_N];
   logic [N_PINS-1:0] ctl_view [CTL_N];
   logic [N_PINS-1:0] sync_q, filt_q, pin_lvl;

   // Input path: synchronizer, then optional per-pin filter.
   gpmx_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_q)
   );

   gpmx_filter #(.W(N_PINS)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(sync_q), .q(filt_q)
   );

   // Control slots: storage where a slot holds state, pin level otherwise.
   for (genvar k = 0; k < CTL_N; k++) begin : g_ctl
      if (k == C_PIN) begin : g_pin
         assign ctl_q[k] = pin_lvl;
      end else begin : g_reg
         logic set_hit, clr_hit;
         assign set_hit = bus_we && (bus_addr == ADDR_W'(4*k + OFS_SET));
         assign clr_hit = bus_we && (bus_addr == ADDR_W'(4*k + OFS_CLR));
         gpmx_setclr #(.W(N_PINS), .RST_VAL(ctl_rst(k))) u_reg (
            .clk(clk), .rst_n(rst_n), .set_we(set_hit), .clr_we(clr_hit),
            .wdata(bus_wdata), .q(ctl_q[k])
         );
      end
      if (ctl_inv(k)) begin : g_inv
         assign ctl_view[k] = ~ctl_q[k];
      end else begin : g_pass
         assign ctl_view[k] = ctl_q[k];
      end
   end

   logic [N_PINS-1:0] own_q, oe_q, flt_q, dout_q, md_q, pu_on_q, sel_a_q;
   assign own_q   = ctl_q[C_OWN];
   assign oe_q    = ctl_q[C_OE];
   assign flt_q   = ctl_q[C_FLT];
   assign dout_q  = ctl_q[C_DOUT];
   assign md_q    = ctl_q[C_MD];
   assign pu_on_q = ctl_q[C_PUON];
   assign sel_a_q = ctl_q[C_SELA];

   assign pin_lvl = (sync_q & ~flt_q) | (filt_q & flt_q);

   // Output path: route mux, ownership mux, then open-drain masking.
   logic [N_PINS-1:0] per_oe, per_out, mux_oe, mux_out;
   assign per_oe  = (pa_oe  & sel_a_q) | (pb_oe  & ~sel_a_q);
   assign per_out = (pa_out & sel_a_q) | (pb_out & ~sel_a_q);
   assign mux_oe  = (oe_q   & own_q)   | (per_oe  & ~own_q);
   assign mux_out = (dout_q & own_q)   | (per_out & ~own_q);

   assign pad_out = mux_out;
   assign pad_oe  = mux_oe & ~(md_q & mux_out);
   assign pad_pu  = pu_on_q;

   // Read port: only status words of mapped slots return data.
   logic [IDX_W-1:0] rd_idx;
   assign rd_idx = bus_addr[IDX_W+1:2];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[1:0] == 2'(OFS_STAT) && bus_addr[ADDR_W-1:IDX_W+2] == '0)
         bus_rdata = ctl_view[rd_idx];
   end
endmodule

// File: rtl/gpmx_bank_chk.sv
`timescale 1ns/1ps
module gpmx_bank_chk
   import gpmx_pkg::*;
#(
   parameter int N_PINS = 32,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [N_PINS-1:0] bus_wdata,
   input logic [N_PINS-1:0] own_q,
   input logic [N_PINS-1:0] oe_q,
   input logic [N_PINS-1:0] flt_q,
   input logic [N_PINS-1:0] dout_q,
   input logic [N_PINS-1:0] md_q,
   input logic [N_PINS-1:0] pu_on_q,
   input logic [N_PINS-1:0] sel_a_q,
   input logic [N_PINS-1:0] sync_q,
   input logic [N_PINS-1:0] filt_q,
   input logic [N_PINS-1:0] pad_oe,
   input logic [N_PINS-1:0] pad_out,
   input logic [N_PINS-1:0] pa_out
);
   logic dout_set_hit, dout_clr_hit, oe_stat_hit;
   assign dout_set_hit = bus_we && bus_addr == ADDR_W'(4*C_DOUT + OFS_SET);
   assign dout_clr_hit = bus_we && bus_addr == ADDR_W'(4*C_DOUT + OFS_CLR);
   assign oe_stat_hit  = bus_we && bus_addr == ADDR_W'(4*C_OE + OFS_STAT);

   a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (own_q == '1 && oe_q == '0 && dout_q == '0 && md_q == '0
                        && flt_q == '0 && pu_on_q == '1 && sel_a_q == '1));

   a_r2_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
      dout_set_hit |=> dout_q == ($past(dout_q) | $past(bus_wdata)));

   a_r2_clear_masks: assert property (@(posedge clk) disable iff (!rst_n)
      dout_clr_hit |=> dout_q == ($past(dout_q) & ~$past(bus_wdata)));

   a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      oe_stat_hit |=> $stable(oe_q));

   a_r6_md_never_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & md_q & pad_out) == '0);

   a_r4_route_a_value: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out ^ pa_out) & ~own_q & sel_a_q) == '0);

   a_r9_filter_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
      ((filt_q ^ $past(filt_q)) & ($past(sync_q) ^ $past(sync_q, 2))) == '0);
endmodule

bind gpmx_bank gpmx_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .own_q(own_q), .oe_q(oe_q), .flt_q(flt_q),
   .dout_q(dout_q), .md_q(md_q), .pu_on_q(pu_on_q), .sel_a_q(sel_a_q),
   .sync_q(sync_q), .filt_q(filt_q), .pad_oe(pad_oe), .pad_out(pad_out),
   .pa_out(pa_out)
);

// File: tb/gpmx_bank_tb_top.sv
`timescale 1ns/1ps
module gpmx_bank_tb_top;
   localparam int K_RD  = 0;
   localparam int K_OE  = 1;
   localparam int K_OUT = 2;
   localparam int K_PU  = 3;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe, pad_out, pad_pu;
   logic [31:0] pa_oe = '0, pa_out = '0, pb_oe = '0, pb_out = '0;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;
   item_t exp_q[$];

   always #2 clk = ~clk;   // 4 ns period

   gpmx_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
      .pa_oe(pa_oe), .pa_out(pa_out), .pb_oe(pb_oe), .pb_out(pb_out)
   );

   // Monitor: pops every expected item at the falling edge and compares.
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = exp_q.pop_front();
         case (it.kind)
            K_RD:    act = bus_rdata;
            K_OE:    act = pad_oe;
            K_OUT:   act = pad_out;
            default: act = pad_pu;
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         n_errors++;
         $display("FAIL watchdog all-reqs actual=timeout expected=done");
         summary();
         $finish;
      end
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic expect_sig(input int kind, input logic [31:0] e, input string tag);
      item_t it;
      it.kind = kind; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      expect_sig(K_RD, e, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(6'd2,  32'hFFFF_FFFF, "R1 own");
      rd(6'd6,  32'h0, "R1 oe");
      rd(6'd14, 32'h0, "R1 dout");
      rd(6'd22, 32'h0, "R1 md");
      rd(6'd10, 32'h0, "R1 flt");
      rd(6'd26, 32'h0, "R1 pullup");
      rd(6'd30, 32'h0, "R1 route");
      expect_sig(K_OE, 32'h0, "R1 pad_oe");
      expect_sig(K_PU, 32'hFFFF_FFFF, "R1 pad_pu");

      // R2: set and clear only touch ones
      wr(6'd12, 32'h0000_00F0);
      rd(6'd14, 32'h0000_00F0, "R2 set");
      wr(6'd12, 32'h0000_0F00);
      rd(6'd14, 32'h0000_0FF0, "R2 set keeps");
      wr(6'd13, 32'h0000_0030);
      rd(6'd14, 32'h0000_0FC0, "R2 clear");

      // R5: GPIO drive
      wr(6'd4, 32'h0000_0FF0);
      rd(6'd6, 32'h0000_0FF0, "R5 oe stat");
      expect_sig(K_OE,  32'h0000_0FF0, "R5 pad_oe");
      expect_sig(K_OUT, 32'h0000_0FC0, "R5 pad_out");

      // R6: multi-drive on GPIO pins
      wr(6'd20, 32'h0000_0F00);
      rd(6'd22, 32'h0000_0F00, "R6 md stat");
      expect_sig(K_OE, 32'h0000_00F0, "R6 float on high");
      wr(6'd13, 32'h0000_0300);
      expect_sig(K_OE,  32'h0000_03F0, "R6 drive low");
      expect_sig(K_OUT, 32'h0000_0CC0, "R6 pad_out");

      // R3/R4: peripheral ownership and route selection
      pa_oe = 32'h00FF_0000; pa_out = 32'h0055_0000;
      pb_oe = 32'hFF00_0000; pb_out = 32'h3C00_0000;
      wr(6'd1, 32'hFFFF_0000);
      rd(6'd2, 32'h0000_FFFF, "R3 own stat");
      expect_sig(K_OE,  32'h00FF_03F0, "R3 route A oe");
      expect_sig(K_OUT, 32'h0055_0CC0, "R3 route A out");
      wr(6'd29, 32'hFF00_0000);
      rd(6'd30, 32'hFF00_0000, "R4 route stat B");
      expect_sig(K_OE,  32'hFFFF_03F0, "R4 route B oe");
      expect_sig(K_OUT, 32'h3C55_0CC0, "R4 route B out");
      wr(6'd28, 32'h0F00_0000);
      rd(6'd30, 32'hF000_0000, "R4 route stat partial");
      expect_sig(K_OE,  32'hF0FF_03F0, "R4 back to A oe");
      expect_sig(K_OUT, 32'h3055_0CC0, "R4 back to A out");
      wr(6'd20, 32'h0001_0000);
      expect_sig(K_OE, 32'hF0FE_03F0, "R6 md on peripheral pin");
      wr(6'd0, 32'hFFFF_0000);
      rd(6'd2, 32'hFFFF_FFFF, "R3 return to GPIO");
      expect_sig(K_OE,  32'h0000_03F0, "R3 GPIO oe again");
      expect_sig(K_OUT, 32'h0000_0CC0, "R3 GPIO out again");

      // R7: pull-up
      wr(6'd25, 32'h0000_000F);
      rd(6'd26, 32'h0000_000F, "R7 disabled stat");
      expect_sig(K_PU, 32'hFFFF_FFF0, "R7 pad_pu off");
      wr(6'd24, 32'h0000_0003);
      rd(6'd26, 32'h0000_000C, "R7 re-enable stat");
      expect_sig(K_PU, 32'hFFFF_FFF3, "R7 pad_pu on");

      // R10: status writes ignored, non-status reads zero
      wr(6'd6, 32'hFFFF_FFFF);
      rd(6'd6, 32'h0000_0FF0, "R10 status write ignored");
      wr(6'd3, 32'hFFFF_FFFF);
      rd(6'd14, 32'h0000_0CC0, "R10 unused write ignored");
      rd(6'd4,  32'h0, "R10 set addr reads 0");
      rd(6'd63, 32'h0, "R10 unmapped reads 0");

      // R8: synchronized level, two-edge latency
      @(posedge clk); #1 pad_in = 32'h1234_5678;
      @(posedge clk);
      rd(6'd18, 32'h0, "R8 not after one edge");
      @(posedge clk);
      rd(6'd18, 32'h1234_5678, "R8 after two edges");

      // R9: filtered pin
      wr(6'd8, 32'h0000_0001);
      rd(6'd10, 32'h0000_0001, "R9 flt stat");
      @(posedge clk); #1 pad_in = 32'h1234_5679;
      repeat (3) @(posedge clk);
      rd(6'd18, 32'h1234_5678, "R9 held after three edges");
      @(posedge clk);
      rd(6'd18, 32'h1234_5679, "R9 passed after four edges");
      @(posedge clk); #1 pad_in = 32'h1234_5678;
      @(posedge clk); #1 pad_in = 32'h1234_5679;
      for (int i = 0; i < 6; i++) begin
         rd(6'd18, 32'h1234_5679, "R9 one-cycle pulse blocked");
      end

      repeat (2) @(posedge clk);
      summary();
      $finish;
   end
endmodule